// File: doc/BRIEF.md
# Match-Compare Interval Timer with Watchdog Reset

The block is a system interval timer. A 32-bit up-counter advances once for each clock cycle in which the external tick-enable input is high. Four compare channels each hold a 32-bit target value. When the counter lands on a channel's target and that channel is enabled, the block latches a sticky status flag and drives that channel's own level interrupt line. Software acknowledges an interrupt by writing a one to the matching status bit.

Channel 3 can also act as a watchdog. If the arm bit of the watchdog register is set when channel 3 fires, the block emits a single-cycle reset request and clears the watchdog register, so the request fires only once. A match on channel 3 triggers the watchdog whether or not its interrupt is enabled.

All state is reached through a simple single-cycle register bus. Reads return their data one cycle after the request. The counter may be overwritten at any time and keeps counting from the value written.

Top module: `ostmr_match_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, the four target registers, the interrupt-enable, status and watchdog registers all read zero. The interrupt lines, the reset request and the error flag are low.
- R2: Register offsets are fixed:
  - targets 0 to 3 at byte offsets 0x00, 0x04, 0x08 and 0x0C;
  - counter at 0x10, status at 0x14, watchdog at 0x18 and interrupt-enable at 0x1C.
  - Read data appears on `bus_rdata` in the cycle after the read request. The interrupt-enable register keeps only bits 11:0 of a write, and the other bits read zero.
- R3: A counter update that lands on target n, with interrupt-enable bit n set, sets status bit n and raises `irq[n]` at the next clock edge. With enable bit n clear, status bit n and `irq[n]` stay low.
- R4: A write to status (0x14) clears each bit that is written as 1. Bits written as 0 keep their value. `irq[n]` falls with its status bit and otherwise stays high.
- R5: While `tick_en` is high, the counter increments by one per clock. A bus write to the counter loads the written value, and counting continues from it. A write wins over a tick in the same cycle.
- R6: When channel 3 fires while bit 0 of the watchdog register is 1, `wdt_rst_req` is high for exactly one cycle and the watchdog register becomes zero. With bit 0 at 0, no request is made and the register keeps its value. Interrupt-enable bit 3 does not matter here.
- R7: A channel fires once for each counter update (tick or write) that leaves the counter equal to its target. An unchanged counter does not fire again. Writing a target equal to the current count does not fire.
- R8: The counter wraps from 0xFFFFFFFF to 0, and a target of 1 fires one tick after the wrap.
- R9: A read from any offset not listed in R2 returns zero and raises `bus_err` for one cycle. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one step per cycle high |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for a read from an undefined offset |
| irq | output | 4 | Per-channel level interrupt, equal to the status flag |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong counter value shows up as an interrupt one cycle late, one cycle early or missing, because every event depends on the cycle in which the counter lands on a target. The bench samples `irq` both in the cycle of the landing update and in the cycle after it. A corrupted status or watchdog register appears on `irq`, on `wdt_rst_req` or in readback within two cycles. The bench counts reset-request pulses over a window, so a request that repeats or fails to disarm is caught at the port.

// File: rtl/ostmr_pkg.sv
// Package: register offsets and shared strobe type for the match timer.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package ostmr_pkg;
    localparam int OFS_MATCH0 = 'h00;
    localparam int OFS_COUNT  = 'h10;
    localparam int OFS_STATUS = 'h14;
    localparam int OFS_WDT    = 'h18;
    localparam int OFS_IEN    = 'h1C;
    localparam int REG_STRIDE = 4;

    typedef struct packed {
        logic count;
        logic status;
        logic wdt;
        logic ien;
    } wr_strobe_t;
endpackage

// File: rtl/ostmr_regbank.sv
// Module: ostmr_regbank
// Decodes bus accesses into write strobes, holds the interrupt-enable
// register and returns registered read data with an error flag.
// Assumes NCHAN targets fit below the counter offset (NCHAN <= 4).
module ostmr_regbank
    import ostmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NCHAN    = 4,
    parameter int IEN_BITS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NCHAN-1:0][DATA_W-1:0] match_vals,
    input  logic [DATA_W-1:0]            count_val,
    input  logic [NCHAN-1:0]             status_val,
    input  logic [DATA_W-1:0]            wdt_val,
    output wr_strobe_t                   wr_stb,
    output logic [NCHAN-1:0]             wr_match,
    output logic [IEN_BITS-1:0]          ien_val,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_err
);
    logic              wr_req;
    logic              rd_req;
    logic              rd_hit;
    logic [DATA_W-1:0] rd_mux;
    logic [IEN_BITS-1:0] ien_q;

    assign wr_req = bus_sel && bus_wr;
    assign rd_req = bus_sel && !bus_wr;

    // Decode write strobes for the target registers.
    always_comb begin
        for (int i = 0; i < NCHAN; i++) begin
            wr_match[i] = wr_req &&
                (bus_addr == ADDR_W'(OFS_MATCH0 + REG_STRIDE * i));
        end
    end

    // Decode write strobes for the fixed registers.
    always_comb begin
        wr_stb.count  = wr_req && (bus_addr == ADDR_W'(OFS_COUNT));
        wr_stb.status = wr_req && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_stb.wdt    = wr_req && (bus_addr == ADDR_W'(OFS_WDT));
        wr_stb.ien    = wr_req && (bus_addr == ADDR_W'(OFS_IEN));
    end

    // Interrupt-enable register, keeps only the low IEN_BITS of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (wr_stb.ien)
            ien_q <= bus_wdata[IEN_BITS-1:0];
    end
    assign ien_val = ien_q;

    // Read multiplexer over every defined offset.
    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b1;
        unique case (bus_addr)
            ADDR_W'(OFS_COUNT):  rd_mux = count_val;
            ADDR_W'(OFS_STATUS): rd_mux = DATA_W'(status_val);
            ADDR_W'(OFS_WDT):    rd_mux = wdt_val;
            ADDR_W'(OFS_IEN):    rd_mux = DATA_W'(ien_q);
            default:             rd_hit = 1'b0;
        endcase
        for (int i = 0; i < NCHAN; i++) begin
            if (bus_addr == ADDR_W'(OFS_MATCH0 + REG_STRIDE * i)) begin
                rd_mux = match_vals[i];
                rd_hit = 1'b1;
            end
        end
    end

    // Registered read data and the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_req ? rd_mux : '0;
            bus_err   <= rd_req && !rd_hit;
        end
    end

    // R9: an error cycle never carries data.
    a_r9_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));
    // R9: an error only follows a read request.
    a_r9_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(rd_req));
endmodule

// File: rtl/ostmr_counter.sv
// Module: ostmr_counter
// Free-running up-counter with a software load, and a flag that marks
// the cycle after any update. Assumes the load has priority over a tick.
module ostmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_o,
    output logic              updated_o
);
    logic [DATA_W-1:0] cnt_q;
    logic              upd_q;

    // Count register: the load wins, otherwise step on tick (wraps naturally).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick_en)
            cnt_q <= cnt_q + DATA_W'(1);
    end

    // Update marker: high for the cycle in which a new count is visible.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else
            upd_q <= load || tick_en;
    end

    assign count_o   = cnt_q;
    assign updated_o = upd_q;

    // R5: a tick with no load steps by exactly one (modulo wrap, R8).
    a_r5_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));
    // R5: a load takes the written value even when a tick is present.
    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/ostmr_match_chan.sv
// Module: ostmr_match_chan
// One compare channel: holds its target and flags a hit when a counter
// update lands on it. Assumes updated_i marks a fresh count value.
module ostmr_match_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_i,
    input  logic              updated_i,
    output logic [DATA_W-1:0] target_o,
    output logic              hit_o
);
    logic [DATA_W-1:0] target_q;

    // Target register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target_q <= '0;
        else if (wr_en)
            target_q <= wdata;
    end

    // Hit: exact equality only in the cycle a new count appears.
    always_comb begin
        hit_o = updated_i && (count_i == target_q);
    end

    assign target_o = target_q;
endmodule

// File: rtl/ostmr_event_ctrl.sv
// Module: ostmr_event_ctrl
// Sticky status flags with write-one-to-clear, level interrupts, and the
// self-disarming watchdog on one channel. A new hit wins over a clear.
module ostmr_event_ctrl #(
    parameter int DATA_W = 32,
    parameter int NCHAN  = 4,
    parameter int WDT_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCHAN-1:0]  hit_i,
    input  logic [NCHAN-1:0]  ien_i,
    input  logic              wr_status,
    input  logic [NCHAN-1:0]  clr_mask,
    input  logic              wr_wdt,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCHAN-1:0]  status_o,
    output logic [DATA_W-1:0] wdt_o,
    output logic              wdt_req_o
);
    logic [NCHAN-1:0]  status_q;
    logic [NCHAN-1:0]  set_v;
    logic [NCHAN-1:0]  clr_v;
    logic [DATA_W-1:0] wdt_q;
    logic              wdt_fire;

    assign set_v    = hit_i & ien_i;
    assign clr_v    = wr_status ? clr_mask : '0;
    assign wdt_fire = hit_i[WDT_CH] && wdt_q[0];

    // Status flags: clear written ones, then apply new enabled hits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_v) | set_v;
    end

    // Watchdog register: disarmed by its own firing, else written by bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_q <= '0;
        else if (wdt_fire)
            wdt_q <= '0;
        else if (wr_wdt)
            wdt_q <= wdata;
    end

    // One-cycle reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_req_o <= 1'b0;
        else
            wdt_req_o <= wdt_fire;
    end

    assign status_o = status_q;
    assign wdt_o    = wdt_q;

    // R3: a flag can only rise where its enable was set.
    a_r3_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(ien_i)) == '0));
    // R4: a written one with no competing hit leaves that flag clear.
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status_q & $past(clr_mask & ~set_v)) == '0));
    // R6: a request is only seen with the watchdog already disarmed.
    a_r6_req_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |-> (wdt_q[0] == 1'b0));
    // R6: the request never lasts beyond one cycle.
    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |=> !wdt_req_o);
endmodule

// File: rtl/ostmr_match_timer.sv
// Module: ostmr_match_timer (top)
// Interval timer with NCHAN compare channels, per-channel level
// interrupts and a one-shot watchdog reset request on channel WDT_CH.
// Assumes a single-cycle register bus with byte offsets.
module ostmr_match_timer
    import ostmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NCHAN    = 4,
    parameter int IEN_BITS = 12,
    parameter int WDT_CH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [NCHAN-1:0]  irq,
    output logic              wdt_rst_req
);
    wr_strobe_t                   wr_stb;
    logic [NCHAN-1:0]             wr_match;
    logic [IEN_BITS-1:0]          ien_val;
    logic [NCHAN-1:0][DATA_W-1:0] match_vals;
    logic [NCHAN-1:0]             hits;
    logic [NCHAN-1:0]             status_val;
    logic [DATA_W-1:0]            count_val;
    logic                         count_upd;
    logic [DATA_W-1:0]            wdt_val;

    ostmr_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCHAN(NCHAN), .IEN_BITS(IEN_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .match_vals(match_vals), .count_val(count_val),
        .status_val(status_val), .wdt_val(wdt_val),
        .wr_stb(wr_stb), .wr_match(wr_match), .ien_val(ien_val),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    ostmr_counter #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load(wr_stb.count), .load_val(bus_wdata),
        .count_o(count_val), .updated_o(count_upd)
    );

    // One compare channel per target register.
    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        ostmr_match_chan #(.DATA_W(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_match[g]), .wdata(bus_wdata),
            .count_i(count_val), .updated_i(count_upd),
            .target_o(match_vals[g]), .hit_o(hits[g])
        );
    end

    ostmr_event_ctrl #(
        .DATA_W(DATA_W), .NCHAN(NCHAN), .WDT_CH(WDT_CH)
    ) u_events (
        .clk(clk), .rst_n(rst_n),
        .hit_i(hits), .ien_i(ien_val[NCHAN-1:0]),
        .wr_status(wr_stb.status), .clr_mask(bus_wdata[NCHAN-1:0]),
        .wr_wdt(wr_stb.wdt), .wdata(bus_wdata),
        .status_o(status_val), .wdt_o(wdt_val), .wdt_req_o(wdt_rst_req)
    );

    assign irq = status_val;

    // R7: a flag never rises without a fresh counter update.
    a_r7_rise_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> $past(count_upd));
endmodule

// File: tb/ostmr_match_timer_test.sv
`timescale 1ns/1ps
module ostmr_match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        wdt_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ostmr_match_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq(irq), .wdt_rst_req(wdt_rst_req)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
        logic        eexp;
    } vec_t;

    // Write-then-read vectors: R2 map and masking, R9 undefined offset.
    localparam vec_t VECS [9] = '{
        '{8'h00, 32'h0000_0011, 32'h0000_0011, 1'b0},
        '{8'h04, 32'h0000_0022, 32'h0000_0022, 1'b0},
        '{8'h08, 32'h0000_0033, 32'h0000_0033, 1'b0},
        '{8'h0C, 32'h0000_0044, 32'h0000_0044, 1'b0},
        '{8'h10, 32'h0000_1234, 32'h0000_1234, 1'b0},
        '{8'h18, 32'h0000_0005, 32'h0000_0005, 1'b0},
        '{8'h1C, 32'hFFFF_F0F0, 32'h0000_00F0, 1'b0},
        '{8'h2C, 32'h0000_ABCD, 32'h0000_0000, 1'b1},
        '{8'h14, 32'h0000_000F, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        int          pulses;
        int          first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports and in every register.
        check("R1 irq", {28'd0, irq}, 32'd0);
        check("R1 req", {31'd0, wdt_rst_req}, 32'd0);
        check("R1 err", {31'd0, bus_err}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            bus_read(8'(a * 4), d, e);
            check("R1 reg zero", d, 32'd0);
        end

        // R2 / R9: table of write-then-read vectors.
        foreach (VECS[i]) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, d, e);
            check(VECS[i].eexp ? "R9 bad offset data" : "R2 readback", d, VECS[i].rexp);
            check(VECS[i].eexp ? "R9 err flag" : "R2 no err", {31'd0, e}, {31'd0, VECS[i].eexp});
        end
        @(negedge clk);
        check("R9 err one cycle", {31'd0, bus_err}, 32'd0);
        bus_write(8'h18, 32'd0);

        // R5: ticking, load, load wins over tick.
        bus_write(8'h10, 32'd100);
        ticks(5);
        bus_read(8'h10, d, e);
        check("R5 count after 5 ticks", d, 32'd105);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd500;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h10, d, e);
        check("R5 load wins", d, 32'd500);
        ticks(1);
        bus_read(8'h10, d, e);
        check("R5 continue after load", d, 32'd501);

        // R3: ch1 enabled and ch2 disabled, both hit at 0x200.
        bus_write(8'h1C, 32'h2);
        bus_write(8'h04, 32'h200);
        bus_write(8'h08, 32'h200);
        bus_write(8'h10, 32'h1FE);
        ticks(2);
        check("R3 irq not before edge", {28'd0, irq}, 32'd0);
        @(negedge clk);
        check("R3 irq ch1 only", {28'd0, irq}, 32'h2);
        bus_read(8'h14, d, e);
        check("R3 status ch1 only", d, 32'h2);

        // R4: write-one-to-clear.
        bus_write(8'h14, 32'hFFFF_FFFD);
        bus_read(8'h14, d, e);
        check("R4 zero bits keep", d, 32'h2);
        check("R4 irq held", {28'd0, irq}, 32'h2);
        bus_write(8'h14, 32'h2);
        bus_read(8'h14, d, e);
        check("R4 cleared", d, 32'h0);
        check("R4 irq dropped", {28'd0, irq}, 32'h0);

        // R7: no refire while held, none on target write, fire on load.
        bus_write(8'h1C, 32'h1);
        bus_write(8'h00, 32'h200);
        repeat (3) @(negedge clk);
        bus_read(8'h14, d, e);
        check("R7 no refire on target write", d, 32'h0);
        bus_write(8'h10, 32'h200);
        @(negedge clk);
        bus_read(8'h14, d, e);
        check("R7 fire on load landing", d, 32'h1);

        // R8: wrap then match at 1.
        bus_write(8'h14, 32'hF);
        bus_write(8'h00, 32'h1);
        bus_write(8'h10, 32'hFFFF_FFFE);
        ticks(2);
        @(negedge clk);
        check("R8 no fire at 0", {28'd0, irq}, 32'h0);
        ticks(1);
        @(negedge clk);
        check("R8 fire after wrap", {28'd0, irq}, 32'h1);
        bus_read(8'h10, d, e);
        check("R8 count wrapped", d, 32'h1);

        // R6: armed watchdog fires once and disarms, interrupt disabled.
        bus_write(8'h14, 32'hF);
        bus_write(8'h1C, 32'h0);
        bus_write(8'h0C, 32'h50);
        bus_write(8'h18, 32'h1);
        bus_write(8'h10, 32'h4E);
        ticks(2);
        pulses = 0; first = -1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (wdt_rst_req) begin
                pulses++;
                if (first < 0) first = c;
            end
        end
        check("R6 one pulse", pulses, 32'd1);
        check("R6 pulse timing", first, 32'd0);
        bus_read(8'h18, d, e);
        check("R6 disarmed", d, 32'h0);
        bus_read(8'h14, d, e);
        check("R6 no status without enable", d, 32'h0);

        // R6: bit 0 clear means no request and value kept.
        bus_write(8'h18, 32'h2);
        bus_write(8'h10, 32'h4E);
        ticks(2);
        pulses = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (wdt_rst_req) pulses++;
        end
        check("R6 unarmed no pulse", pulses, 32'd0);
        bus_read(8'h18, d, e);
        check("R6 unarmed keeps value", d, 32'h2);

        // R9: undefined read, then flag drops.
        bus_read(8'h24, d, e);
        check("R9 bad read data", d, 32'h0);
        check("R9 bad read err", {31'd0, e}, 32'd1);
        @(negedge clk);
        check("R9 err cleared", {31'd0, bus_err}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule